// File: doc/BRIEF.md
# Regulator Control and Status Register File

This block is the register file of a switching-regulator controller. A simple synchronous port with an address, write data, a write strobe, a read strobe and registered read data reaches five byte-wide registers. These are the output setpoint code, three control registers and one status register. The control fields are decoded and driven out as dedicated signals to the regulator logic. The forced-PWM request is merged with an external mode pin before it leaves the block.

Hardware event pulses (hiccup, current limit, thermal warning, thermal shutdown, under- and overvoltage) are caught in sticky flags. Reading the status register returns the flags and clears them. An event that arrives in the same cycle as that read is kept. A strap pin chooses the setpoint's reset code between two parameter values. The pin is sampled only while the hardware reset is held. A software reset command in control register 1 returns every register to its default value.

Top module: `regctl_top`

## Requirements
- R1: While `rst` is high, and after it falls with no access, the registers read: address 1 = 0x2A, address 2 = 0x09, address 3 = 0x00, address 4 = 0x02 (undervoltage flag set, all other flags clear).
- R2: The setpoint (address 0) resets to `SP_CODE_HI` if `strap_sel` is 1 during hardware reset and to `SP_CODE_LO` if it is 0. A later software reset uses the level latched during hardware reset, not the present pin level.
- R3: Writable fields store the written value and drive the outputs. Address 0 drives `sp_code`. Address 1 bit 6 drives `ssc_en`, bit 5 `sw_en`, bit 3 `dis_en`, bit 2 `hiccup_en` and bits 1:0 `ramp_sel`. Address 2 bits 3:2 drive `vrange` and bits 1:0 `ss_time`. Address 3 bit 1 drives `single_op` and bit 0 `pg_blank`.
- R4: Bits 7:4 of address 2 and bits 7:2 of address 3 always read 0, whatever is written.
- R5: Address 1 bit 7 always reads 0. Writing it as 1 restores every register to its R1/R2 default from the next cycle, and the other bits of that write are discarded.
- R6: A one-cycle pulse on `evt_in[i]` sets status bit i (bit 5 hiccup, 4 current limit, 3 thermal warning, 2 thermal shutdown, 1 undervoltage, 0 overvoltage), and the bit stays set until the status register is read. Status bits 7:6 read 0.
- R7: A read of address 4 returns the flags and clears them. A flag whose event pulses in the same cycle as the read stays set afterwards.
- R8: Writes to address 4 and to addresses 5 to 7 change nothing. Reads of addresses 5 to 7 return 0.
- R9: `fpwm_eff` is the OR of address 1 bit 4 and `mode_pin`, registered, so it follows one cycle after either input.
- R10: `rdata` updates on the clock edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| strap_sel | input | 1 | Strap level that selects the setpoint reset code |
| mode_pin | input | 1 | External forced-PWM request |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| evt_in | input | 6 | Event pulses, bit order as the status register |
| sp_code | output | 8 | Setpoint code |
| ssc_en | output | 1 | Spread-spectrum enable |
| sw_en | output | 1 | Switching enable |
| fpwm_eff | output | 1 | Effective forced-PWM request |
| dis_en | output | 1 | Output discharge enable |
| hiccup_en | output | 1 | Hiccup operation enable |
| ramp_sel | output | 2 | Ramp speed select |
| vrange | output | 2 | Output voltage range |
| ss_time | output | 2 | Soft-start time select |
| single_op | output | 1 | Single-operation select |
| pg_blank | output | 1 | Power-good blanking during setpoint change |

## Verification
The bench drives an event into the same cycle as a status read. A design that cleared the flag after its read would lose that event, and the next read would show 0 where the model expects 1. The strap pin is changed after reset and a software reset is then issued. A design that re-sampled the pin would load the other setpoint code. The bench writes all ones to the read-only bits, the reset bit, the status address and the reserved addresses. Any stored bit, any visible reset bit, or any reserved read that is not 0 then shows up as a mismatch against the per-clock model. That model also checks that the undervoltage flag comes back set after both kinds of reset.

// File: rtl/regctl_pkg.sv
package regctl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_EVT = 6;
  localparam int NUM_CTL = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SETPT = 3'd0,
    A_CTL1  = 3'd1,
    A_CTL2  = 3'd2,
    A_CTL3  = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;

  localparam logic [NUM_EVT-1:0] STAT_DEF = 6'b000010;

  function automatic logic [DATA_W-1:0] ctl_default(input int idx);
    case (idx)
      1:       return 8'h2A;
      2:       return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ctl_wmask(input int idx);
    case (idx)
      1:       return 8'h7F;
      2:       return 8'h0F;
      default: return 8'h03;
    endcase
  endfunction
endpackage

// File: rtl/regctl_cfg_regs.sv
module regctl_cfg_regs
  import regctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] SP_CODE_LO = 8'h50,
  parameter logic [DATA_W-1:0] SP_CODE_HI = 8'hA0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          strap_sel,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          soft_rst,
  output logic [DATA_W-1:0]             setpt_q,
  output logic [NUM_CTL:1][DATA_W-1:0]  ctl_q
);
  logic strap_q;

  assign soft_rst = wr_en && (addr == A_CTL1) && wdata[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)
      setpt_q <= strap_sel ? SP_CODE_HI : SP_CODE_LO;
    else if (soft_rst)
      setpt_q <= strap_q ? SP_CODE_HI : SP_CODE_LO;
    else if (wr_en && addr == A_SETPT)
      setpt_q <= wdata;
  end

  for (genvar g = 1; g <= NUM_CTL; g++) begin : g_ctl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        ctl_q[g] <= ctl_default(g);
      else if (wr_en && addr == MY_ADDR)
        ctl_q[g] <= wdata & ctl_wmask(g);
    end
  end
endmodule

// File: rtl/regctl_status_flags.sv
module regctl_status_flags
  import regctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               clr_rd,
  input  logic [NUM_EVT-1:0] evt,
  output logic [NUM_EVT-1:0] flags
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= STAT_DEF[g];
      else if (soft_rst)
        flags[g] <= STAT_DEF[g] | evt[g];
      else if (clr_rd)
        flags[g] <= evt[g];
      else if (evt[g])
        flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/regctl_rd_port.sv
module regctl_rd_port
  import regctl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             setpt_q,
  input  logic [NUM_CTL:1][DATA_W-1:0]  ctl_q,
  input  logic [NUM_EVT-1:0]            flags,
  output logic                          stat_rd,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] sel;

  assign stat_rd = rd_en && (addr == A_STAT);

  always_comb begin
    case (addr)
      A_SETPT: sel = setpt_q;
      A_CTL1:  sel = ctl_q[1] & ctl_wmask(1);
      A_CTL2:  sel = ctl_q[2] & ctl_wmask(2);
      A_CTL3:  sel = ctl_q[3] & ctl_wmask(3);
      A_STAT:  sel = {{(DATA_W-NUM_EVT){1'b0}}, flags};
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/regctl_top.sv
module regctl_top
  import regctl_pkg::*;
#(
  parameter logic [7:0] SP_CODE_LO = 8'h50,
  parameter logic [7:0] SP_CODE_HI = 8'hA0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_sel,
  input  logic       mode_pin,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic [5:0] evt_in,
  output logic [7:0] sp_code,
  output logic       ssc_en,
  output logic       sw_en,
  output logic       fpwm_eff,
  output logic       dis_en,
  output logic       hiccup_en,
  output logic [1:0] ramp_sel,
  output logic [1:0] vrange,
  output logic [1:0] ss_time,
  output logic       single_op,
  output logic       pg_blank
);
  logic                         soft_rst;
  logic                         stat_rd;
  logic [DATA_W-1:0]            setpt_q;
  logic [NUM_CTL:1][DATA_W-1:0] ctl_q;
  logic [NUM_EVT-1:0]           stat_flags;
  logic                         fpwm_q;

  regctl_cfg_regs #(.SP_CODE_LO(SP_CODE_LO), .SP_CODE_HI(SP_CODE_HI)) u_cfg (
    .clk(clk), .rst(rst), .strap_sel(strap_sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .soft_rst(soft_rst), .setpt_q(setpt_q), .ctl_q(ctl_q)
  );

  regctl_status_flags u_stat (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .clr_rd(stat_rd),
    .evt(evt_in), .flags(stat_flags)
  );

  regctl_rd_port u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .setpt_q(setpt_q),
    .ctl_q(ctl_q), .flags(stat_flags), .stat_rd(stat_rd), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) fpwm_q <= 1'b0;
    else     fpwm_q <= ctl_q[1][4] | mode_pin;
  end

  assign fpwm_eff  = fpwm_q;
  assign sp_code   = setpt_q;
  assign ssc_en    = ctl_q[1][6];
  assign sw_en     = ctl_q[1][5];
  assign dis_en    = ctl_q[1][3];
  assign hiccup_en = ctl_q[1][2];
  assign ramp_sel  = ctl_q[1][1:0];
  assign vrange    = ctl_q[2][3:2];
  assign ss_time   = ctl_q[2][1:0];
  assign single_op = ctl_q[3][1];
  assign pg_blank  = ctl_q[3][0];
endmodule

// File: rtl/regctl_sva.sv
module regctl_sva (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic [5:0] evt_in,
  input logic [5:0] flags,
  input logic       mode_pin,
  input logic       fpwm_eff
);
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_ro_ctl2_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd2) |=> rdata[7:4] == 4'd0);

  assert_rst_bit_reads0_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1) |=> !rdata[7]);

  assert_evt_sticks_R6: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((flags & $past(evt_in)) == $past(evt_in)));

  assert_reserved_read0_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > 3'd4) |=> rdata == 8'd0);

  assert_mode_forces_pwm_R9: assert property (@(posedge clk) disable iff (rst)
    mode_pin |=> fpwm_eff);
endmodule

bind regctl_top regctl_sva u_sva (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .evt_in(evt_in), .flags(stat_flags), .mode_pin(mode_pin), .fpwm_eff(fpwm_eff)
);

// File: tb/regctl_top_tb.sv
module regctl_top_tb;
  localparam logic [7:0] LO = 8'h50;
  localparam logic [7:0] HI = 8'hA0;

  logic clk = 0, rst = 1, strap_sel = 1, mode_pin = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, sp_code;
  logic [5:0] evt_in = 0;
  logic ssc_en, sw_en, fpwm_eff, dis_en, hiccup_en, single_op, pg_blank;
  logic [1:0] ramp_sel, vrange, ss_time;

  int errors = 0, checks = 0;

  regctl_top #(.SP_CODE_LO(LO), .SP_CODE_HI(HI)) u_dut (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int m_sp, m_c1, m_c2, m_c3, m_st, m_rd, m_fp, m_strap;
  bit m_valid = 0;

  function automatic int m_read(int a);
    case (a)
      0: return m_sp;
      1: return m_c1;
      2: return m_c2;
      3: return m_c3;
      4: return m_st;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nst, nfp;
    if (rst) begin
      m_strap = strap_sel; m_sp = strap_sel ? HI : LO;
      m_c1 = 'h2A; m_c2 = 'h09; m_c3 = 0; m_st = 2; m_rd = 0; m_fp = 0;
      m_valid = 1;
    end else begin
      nfp = ((m_c1 >> 4) & 1) | mode_pin;
      nst = m_st | evt_in;
      if (rd_en) begin
        m_rd = m_read(addr);
        if (addr == 4) nst = evt_in;
      end
      if (wr_en) begin
        if (addr == 1 && wdata[7]) begin
          m_sp = m_strap ? HI : LO; m_c1 = 'h2A; m_c2 = 'h09; m_c3 = 0;
          nst = 2 | evt_in;
        end else if (addr == 0) m_sp = wdata;
        else if (addr == 1) m_c1 = wdata & 'h7F;
        else if (addr == 2) m_c2 = wdata & 'h0F;
        else if (addr == 3) m_c3 = wdata & 'h03;
      end
      m_st = nst; m_fp = nfp;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk("R10 rdata", rdata, m_rd);
      chk("R3 sp_code", sp_code, m_sp);
      chk("R3 ctl1 fields", {ssc_en, sw_en, 1'b0, dis_en, hiccup_en, ramp_sel},
          m_c1 & 'h6F);
      chk("R3 ctl2/3 fields", {vrange, ss_time, single_op, pg_blank},
          ((m_c2 & 'hF) << 2) | m_c3);
      chk("R9 fpwm_eff", fpwm_eff, m_fp);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 3'(a); rd_en = 1;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic hard_reset(bit s);
    @(negedge clk); rst = 1; strap_sel = s;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    hard_reset(1);
    rd(1, v); chk("R1 ctl1 default", v, 'h2A);
    rd(2, v); chk("R1 ctl2 default", v, 'h09);
    rd(3, v); chk("R1 ctl3 default", v, 'h00);
    rd(0, v); chk("R2 setpoint strap high", v, HI);
    rd(4, v); chk("R1 status default", v, 'h02);
    rd(4, v); chk("R7 status cleared", v, 'h00);

    // R3 writable fields
    wr(0, 'h33); rd(0, v); chk("R3 setpoint write", v, 'h33);
    wr(1, 'h55); rd(1, v); chk("R3 ctl1 write", v, 'h55);
    chk("R3 ssc_en out", ssc_en, 1);
    wr(2, 'h06); chk("R3 vrange out", vrange, 1);
    // R4 read-only bits
    wr(2, 'hFF); rd(2, v); chk("R4 ctl2 ro bits", v, 'h0F);
    wr(3, 'hFF); rd(3, v); chk("R4 ctl3 ro bits", v, 'h03);
    // R5 reset bit and R2 latched strap
    strap_sel = 0;
    wr(1, 'hFF); rd(1, v); chk("R5 soft reset ctl1", v, 'h2A);
    rd(2, v); chk("R5 soft reset ctl2", v, 'h09);
    rd(3, v); chk("R5 soft reset ctl3", v, 'h00);
    rd(0, v); chk("R2 soft reset uses latched strap", v, HI);
    rd(4, v); chk("R5 soft reset status", v, 'h02);
    wr(1, 'h7F); rd(1, v); chk("R5 bit7 reads 0", v, 'h7F);

    // R6 sticky events
    @(negedge clk); evt_in = 6'b100001;
    @(negedge clk); evt_in = 0;
    repeat (3) @(negedge clk);
    rd(4, v); chk("R6 flags sticky", v, 'h21);
    rd(4, v); chk("R7 clear on read", v, 0);
    // R7 event concurrent with read
    @(negedge clk); evt_in = 6'b000100;
    @(negedge clk); evt_in = 6'b001000; addr = 4; rd_en = 1;
    @(negedge clk); evt_in = 0; rd_en = 0; v = rdata;
    chk("R7 read returns earlier flag", v, 'h04);
    rd(4, v); chk("R7 concurrent event kept", v, 'h08);

    // R8 ignored writes and reserved reads
    wr(4, 'hFF); wr(5, 'hFF); wr(7, 'hFF);
    rd(4, v); chk("R8 status write ignored", v, 0);
    rd(6, v); chk("R8 reserved read", v, 0);
    rd(5, v); chk("R8 reserved read 5", v, 0);
    rd(1, v); chk("R8 ctl1 untouched", v, 'h7F);

    // R9 mode pin
    wr(1, 'h00);
    @(negedge clk); mode_pin = 1;
    @(negedge clk); chk("R9 mode pin forces pwm", fpwm_eff, 1);
    mode_pin = 0;
    @(negedge clk); chk("R9 pwm released", fpwm_eff, 0);
    wr(1, 'h10);
    @(negedge clk); chk("R9 register bit forces pwm", fpwm_eff, 1);

    // R10 hold
    rd(0, v);
    repeat (4) @(negedge clk);
    chk("R10 rdata held", rdata, v);

    // R2 strap low
    hard_reset(0);
    rd(0, v); chk("R2 setpoint strap low", v, LO);
    rd(4, v); chk("R1 status after second reset", v, 'h02);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule